// File: doc/BRIEF.md
# Quad UART Shared-Interrupt Multiplexer

This block sits between a host I/O bus and four byte-wide UART cores that are laid out back to back in one 32-byte I/O window. It turns each host access into a chip select, a register offset and a read or write strobe for the addressed UART. All four UART interrupt outputs are merged into one interrupt request for the host, and the host treats that request as edge-triggered.

One location is taken over by the block. It is the scratch-register slot of the first channel. A write to this slot stores a per-channel interrupt enable mask. A read from it returns a bitmap of the channels that have an enabled interrupt pending. The unused upper bits of the bitmap always read as ones. The mask is not reset and holds an arbitrary value after power-up, so software must load it before it relies on interrupts.

A service routine reads the bitmap. It then queries each flagged UART for the cause, and reads the bitmap again until the bitmap is zero. Because of this loop, an interrupt that arrives while another one is still pending is not lost, even though the shared line produces no new edge for it.

Top module: `quad_irq_mux`

## Requirements
- R1: A bus access whose address is not 5'b00111 asserts only uartSel[n], where n = busAddr[4:3]. It drives uartOffs = busAddr[2:0], and uartWrEn/uartRdEn follow busWrEn/busRdEn. This includes offset 7 of channels 1 to 3.
- R2: An access to address 5'b00111 (the control slot) asserts no uartSel bit and neither UART strobe.
- R3: A write to the control slot loads the enable mask from busWrData[3:0]. Bit n = 1 enables channel n and bit n = 0 blocks it.
- R4: A read of the control slot returns {4'b1111, pending} on busRdData on the cycle after the read strobe, where pending[n] = uartIrq[n] AND mask[n].
- R5: A read of any other address returns the addressed channel's byte uartRdData[8n+7:8n] on busRdData on the cycle after the read strobe.
- R6: irqOut is registered. It equals the OR of the four pending bits, sampled at the previous clock edge.
- R7: While the mask is zero, irqOut stays low whatever the UART interrupt inputs do, and the pending field reads 4'b0000.
- R8: When a second channel raises its interrupt while another is still pending, irqOut stays high with no new rising edge. The bitmap shows both channels until each source drops.
- R9: A control read has no side effect. Repeated reads return the same bitmap, and irqOut is unchanged. A pending bit clears only when its source input drops.
- R10: During reset, irqOut and busRdData are 0. The enable mask is not reset and is undefined until the first control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Host byte address within the 32-byte window |
| busWrEn | input | 1 | Host write strobe |
| busRdEn | input | 1 | Host read strobe |
| busWrData | input | 8 | Host write data |
| busRdData | output | 8 | Host read data, valid the cycle after the read strobe |
| uartIrq | input | 4 | Interrupt outputs of the four UARTs |
| uartRdData | input | 32 | Read data of the four UARTs, channel n in bits 8n+7:8n |
| uartSel | output | 4 | One-hot UART chip selects |
| uartOffs | output | 3 | Register offset inside the selected UART |
| uartWrEn | output | 1 | Write strobe to the selected UART |
| uartRdEn | output | 1 | Read strobe to the selected UART |
| uartWrData | output | 8 | Write data passed through to the UARTs |
| irqOut | output | 1 | Shared interrupt request to the host |

## Verification
Chip selects, offsets and UART strobes are combinational, so the bench checks them shortly after it drives the address, in the same cycle. Read data and irqOut each come from one register. The bench drives inputs on a falling edge and samples on the next falling edge, which leaves exactly one rising edge between stimulus and check. A mask write takes effect at the edge that ends the write cycle, so an interrupt source that changes in the same cycle shows on irqOut one cycle later. Rising edges of irqOut are counted separately. This shows that a second source adds no edge, and that the service loop still finds that source in the bitmap.

// File: rtl/qim_pkg.sv
package qim_pkg;
  localparam int QM_NUM_CH   = 4;
  localparam int QM_DATA_W   = 8;
  localparam int QM_REG_SPAN = 8;
  localparam int QM_CH_W     = $clog2(QM_NUM_CH);

  typedef struct packed {
    logic               ctrlWr;
    logic               ctrlRd;
    logic               uartRd;
    logic [QM_CH_W-1:0] chanIdx;
  } qim_strobe_t;
endpackage

// File: rtl/qim_decode.sv
module qim_decode
  import qim_pkg::*;
#(
  parameter int NUM_CH   = QM_NUM_CH,
  parameter int REG_SPAN = QM_REG_SPAN,
  localparam int OFFS_W  = $clog2(REG_SPAN),
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int ADDR_W  = OFFS_W + CH_W
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output qim_strobe_t       strb,
  output logic [NUM_CH-1:0] uartSel,
  output logic [OFFS_W-1:0] uartOffs,
  output logic              uartWrEn,
  output logic              uartRdEn
);
  // control slot: scratch offset (last in span) of channel 0
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(REG_SPAN - 1);

  logic ctrlHit;
  logic uartHit;
  logic [CH_W-1:0] chanIdx;

  assign ctrlHit = (busAddr == CTRL_ADDR);
  assign uartHit = (busWrEn | busRdEn) & ~ctrlHit;
  assign chanIdx = busAddr[ADDR_W-1:OFFS_W];

  always_comb begin
    strb         = '0;
    strb.ctrlWr  = busWrEn & ctrlHit;
    strb.ctrlRd  = busRdEn & ctrlHit;
    strb.uartRd  = busRdEn & ~ctrlHit;
    strb.chanIdx = chanIdx;
  end

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_sel
      assign uartSel[n] = uartHit && (chanIdx == CH_W'(n));
    end
  endgenerate

  assign uartOffs = busAddr[OFFS_W-1:0];
  assign uartWrEn = busWrEn & ~ctrlHit;
  assign uartRdEn = busRdEn & ~ctrlHit;
endmodule

// File: rtl/qim_datapath.sv
module qim_datapath
  import qim_pkg::*;
#(
  parameter int NUM_CH = QM_NUM_CH,
  parameter int DATA_W = QM_DATA_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  qim_strobe_t              strb,
  input  logic [NUM_CH-1:0]        wrMask,
  input  logic [NUM_CH-1:0]        uartIrq,
  input  logic [NUM_CH*DATA_W-1:0] uartRdData,
  output logic [DATA_W-1:0]        busRdData,
  output logic                     irqOut
);
  // enable mask: deliberately no reset, power-up value is arbitrary
  logic [NUM_CH-1:0] maskReg;
  logic [NUM_CH-1:0] pendBits;
  logic [DATA_W-1:0] ctrlWord;
  logic [DATA_W-1:0] chanByte [NUM_CH];
  logic [DATA_W-1:0] rdDataQ;
  logic              irqQ;

  always_ff @(posedge clk) begin
    if (strb.ctrlWr) maskReg <= wrMask;
  end

  assign pendBits = uartIrq & maskReg;

  generate
    if (DATA_W > NUM_CH) begin : g_pad
      assign ctrlWord = {{(DATA_W - NUM_CH){1'b1}}, pendBits};
    end else begin : g_nopad
      assign ctrlWord = pendBits[DATA_W-1:0];
    end
    for (genvar n = 0; n < NUM_CH; n++) begin : g_byte
      assign chanByte[n] = uartRdData[n*DATA_W +: DATA_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDataQ <= '0;
      irqQ    <= 1'b0;
    end else begin
      irqQ <= |pendBits;
      if (strb.ctrlRd)      rdDataQ <= ctrlWord;
      else if (strb.uartRd) rdDataQ <= chanByte[strb.chanIdx];
    end
  end

  assign busRdData = rdDataQ;
  assign irqOut    = irqQ;
endmodule

// File: rtl/quad_irq_mux.sv
module quad_irq_mux
  import qim_pkg::*;
#(
  parameter int NUM_CH   = QM_NUM_CH,
  parameter int DATA_W   = QM_DATA_W,
  parameter int REG_SPAN = QM_REG_SPAN,
  localparam int OFFS_W  = $clog2(REG_SPAN),
  localparam int ADDR_W  = OFFS_W + $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWrEn,
  input  logic                     busRdEn,
  input  logic [DATA_W-1:0]        busWrData,
  output logic [DATA_W-1:0]        busRdData,
  input  logic [NUM_CH-1:0]        uartIrq,
  input  logic [NUM_CH*DATA_W-1:0] uartRdData,
  output logic [NUM_CH-1:0]        uartSel,
  output logic [OFFS_W-1:0]        uartOffs,
  output logic                     uartWrEn,
  output logic                     uartRdEn,
  output logic [DATA_W-1:0]        uartWrData,
  output logic                     irqOut
);
  qim_strobe_t strb;

  qim_decode #(.NUM_CH(NUM_CH), .REG_SPAN(REG_SPAN)) u_decode (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strb    (strb),
    .uartSel (uartSel),
    .uartOffs(uartOffs),
    .uartWrEn(uartWrEn),
    .uartRdEn(uartRdEn)
  );

  qim_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrMask    (busWrData[NUM_CH-1:0]),
    .uartIrq   (uartIrq),
    .uartRdData(uartRdData),
    .busRdData (busRdData),
    .irqOut    (irqOut)
  );

  assign uartWrData = busWrData;
endmodule

// File: rtl/qim_checker.sv
module qim_checker #(
  parameter int NUM_CH   = 4,
  parameter int DATA_W   = 8,
  parameter int REG_SPAN = 8,
  localparam int OFFS_W  = $clog2(REG_SPAN),
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int ADDR_W  = OFFS_W + CH_W
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [ADDR_W-1:0]        busAddr,
  input logic                     busWrEn,
  input logic                     busRdEn,
  input logic [DATA_W-1:0]        busWrData,
  input logic [DATA_W-1:0]        busRdData,
  input logic [NUM_CH-1:0]        uartIrq,
  input logic [NUM_CH*DATA_W-1:0] uartRdData,
  input logic [NUM_CH-1:0]        uartSel,
  input logic                     irqOut
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(REG_SPAN - 1);

  logic              ctrlAcc;
  logic              anyAcc;
  logic [CH_W-1:0]   chan;
  logic [DATA_W-1:0] expByte;
  logic [NUM_CH-1:0] shadowMask;
  logic              maskKnown;
  logic [NUM_CH-1:0] expPend;

  assign anyAcc  = busWrEn | busRdEn;
  assign ctrlAcc = anyAcc && (busAddr == CTRL_ADDR);
  assign chan    = busAddr[ADDR_W-1:OFFS_W];
  assign expByte = uartRdData[chan*DATA_W +: DATA_W];
  assign expPend = uartIrq & shadowMask;

  always_ff @(posedge clk) begin
    if (busWrEn && busAddr == CTRL_ADDR) shadowMask <= busWrData[NUM_CH-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) maskKnown <= 1'b0;
    else if (busWrEn && busAddr == CTRL_ADDR) maskKnown <= 1'b1;
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(uartSel));  // R1
  AST_SEL_ADDRESSED: assert property (@(posedge clk) disable iff (!rstN)
    (anyAcc && !ctrlAcc) |-> uartSel[chan]);  // R1
  AST_CTRL_NO_SEL: assert property (@(posedge clk) disable iff (!rstN)
    ctrlAcc |-> (uartSel == '0));  // R2
  AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rstN)
    (maskKnown && busRdEn && busAddr == CTRL_ADDR) |=>
      (busRdData[NUM_CH-1:0] == $past(expPend) && (&busRdData[DATA_W-1:NUM_CH])));  // R4
  AST_UART_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr != CTRL_ADDR) |=> (busRdData == $past(expByte)));  // R5
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (maskKnown && |expPend) |=> irqOut);  // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (maskKnown && expPend == '0) |=> !irqOut);  // R7
  AST_NO_REEDGE: assert property (@(posedge clk) disable iff (!rstN)
    (maskKnown && irqOut && $past(|expPend) && |expPend) |=> $stable(irqOut));  // R8
endmodule

bind quad_irq_mux qim_checker #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .REG_SPAN(REG_SPAN)
) u_qim_checker (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busRdEn   (busRdEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .uartIrq   (uartIrq),
  .uartRdData(uartRdData),
  .uartSel   (uartSel),
  .irqOut    (irqOut)
);

// File: tb/test_quad_irq_mux.sv
`timescale 1ns/1ps
module test_quad_irq_mux;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [3:0]  uartIrq = '0;
  logic [31:0] uartRdData = 32'hD3C2B1A0;
  logic [3:0]  uartSel;
  logic [2:0]  uartOffs;
  logic        uartWrEn;
  logic        uartRdEn;
  logic [7:0]  uartWrData;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;
  int riseCnt = 0;
  logic irqPrev = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  quad_irq_mux i_quad_irq_mux (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .uartIrq(uartIrq), .uartRdData(uartRdData), .uartSel(uartSel),
    .uartOffs(uartOffs), .uartWrEn(uartWrEn), .uartRdEn(uartRdEn),
    .uartWrData(uartWrData), .irqOut(irqOut)
  );

  always @(posedge clk) begin
    irqPrev <= irqOut;
    if (irqOut && !irqPrev) riseCnt <= riseCnt + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    d = busRdData;
    busRdEn = 1'b0;
  endtask

  // {mask[15:12], src[11:8], expBits[7:4], expIrq[0]}
  localparam logic [15:0] VEC [8] = '{
    16'hF1_11, 16'hF0_00, 16'hFA_A1, 16'h5A_00,
    16'h5F_51, 16'h87_00, 16'h88_81, 16'hC6_41
  };

  initial begin
    #(8 * 20000);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] rd2;
    int base;
    bit sawLate;
    int loops;

    // R10: reset state
    repeat (3) @(negedge clk);
    check(irqOut == 1'b0, "R10 irq in reset", irqOut, 0);
    check(busRdData == 8'h00, "R10 rdData in reset", busRdData, 0);
    rstN = 1'b1;

    // R7: mask zero keeps line quiet
    busWrite(5'd7, 8'h00);
    uartIrq = 4'hF;
    repeat (3) begin
      @(negedge clk);
      check(irqOut == 1'b0, "R7 mask zero irq", irqOut, 0);
    end
    busRead(5'd7, rd);
    check(rd == 8'hF0, "R7 mask zero bitmap", rd, 8'hF0);
    uartIrq = 4'h0;

    // R3 R4 R6: vector table
    for (int i = 0; i < 8; i++) begin
      busWrite(5'd7, {4'h0, VEC[i][15:12]});
      uartIrq = VEC[i][11:8];
      @(negedge clk);
      check(irqOut == VEC[i][0], "R6 irq vector", irqOut, VEC[i][0]);
      busRead(5'd7, rd);
      check(rd == {4'hF, VEC[i][7:4]}, "R3 R4 bitmap vector", rd, {4'hF, VEC[i][7:4]});
    end
    uartIrq = 4'h0;

    // R1 R2: decode, checked combinationally
    @(negedge clk);
    busAddr = 5'd19; busWrData = 8'h5C; busWrEn = 1'b1; #1;
    check(uartSel == 4'b0100 && uartOffs == 3'd3 && uartWrEn && !uartRdEn,
          "R1 ch2 off3 write", {uartSel, uartOffs, uartWrEn}, {4'b0100, 3'd3, 1'b1});
    check(uartWrData == 8'h5C, "R1 write data", uartWrData, 8'h5C);
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 5'd15; busRdEn = 1'b1; #1;
    check(uartSel == 4'b0010 && uartOffs == 3'd7 && uartRdEn,
          "R1 ch1 scratch passes", {uartSel, uartOffs, uartRdEn}, {4'b0010, 3'd7, 1'b1});
    @(negedge clk);
    busRdEn = 1'b0; busAddr = 5'd7; busWrEn = 1'b1; busWrData = 8'h0F; #1;
    check(uartSel == 4'b0000 && !uartWrEn, "R2 ctrl write no select", {uartSel, uartWrEn}, 0);
    @(negedge clk);
    busWrEn = 1'b0; busRdEn = 1'b1; #1;
    check(uartSel == 4'b0000 && !uartRdEn, "R2 ctrl read no select", {uartSel, uartRdEn}, 0);
    @(negedge clk);
    busRdEn = 1'b0;

    // R5: UART read data routing
    busRead(5'd24, rd);
    check(rd == 8'hD3, "R5 ch3 read", rd, 8'hD3);
    busRead(5'd6, rd);
    check(rd == 8'hA0, "R5 ch0 read", rd, 8'hA0);
    busRead(5'd31, rd);
    check(rd == 8'hD3, "R5 ch3 scratch read", rd, 8'hD3);

    // R8: late source, no new edge, service loop still finds it
    busWrite(5'd7, 8'h0F);
    @(negedge clk);
    base = riseCnt;
    uartIrq = 4'b0001;
    repeat (2) @(negedge clk);
    check(irqOut == 1'b1, "R8 first source irq", irqOut, 1);
    uartIrq = 4'b0011;
    repeat (2) @(negedge clk);
    check(irqOut == 1'b1, "R8 irq held", irqOut, 1);
    check(riseCnt - base == 1, "R8 single edge", riseCnt - base, 1);
    sawLate = 1'b0;
    loops = 0;
    busRead(5'd7, rd);
    while (rd[3:0] != 4'h0 && loops < 8) begin
      if (rd[1]) sawLate = 1'b1;
      uartIrq = uartIrq & ~rd[3:0] & (loops == 0 ? 4'b1110 : 4'b0000);
      loops++;
      busRead(5'd7, rd);
    end
    check(sawLate, "R8 loop sees late source", sawLate, 1);
    check(rd == 8'hF0, "R8 loop ends clear", rd, 8'hF0);
    @(negedge clk);
    check(irqOut == 1'b0, "R8 irq drops", irqOut, 0);
    check(riseCnt - base == 1, "R8 still single edge", riseCnt - base, 1);

    // R9: reads have no side effect
    uartIrq = 4'b0101;
    repeat (2) @(negedge clk);
    busRead(5'd7, rd);
    busRead(5'd7, rd2);
    check(rd == 8'hF5 && rd2 == 8'hF5, "R9 repeat read", {rd, rd2}, 16'hF5F5);
    check(irqOut == 1'b1, "R9 irq unchanged by read", irqOut, 1);
    uartIrq = 4'b0100;
    @(negedge clk);
    busRead(5'd7, rd);
    check(rd == 8'hF4, "R9 bit clears with source", rd, 8'hF4);
    uartIrq = 4'b0000;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule